// File: doc/BRIEF.md
# Port Pin Controller

This block controls one eight-pin general-purpose port. Software sets each pin's direction, picks whether an output pin is driven by a register bit or by an on-chip peripheral, turns off the digital input buffer of pins used for analog signals, and enables a change interrupt for each pin. One register bit has two jobs. On an output pin it gives the drive level. On an input pin it turns on the pull-up.

The pad input goes through a two-flop synchronizer. A read of the pin register returns the synchronized level and takes a snapshot of it. Each pin has a two-state change tracker with the states CHG_IDLE and CHG_PEND:

- **CHG_IDLE to CHG_PEND** happens when the pin is armed and its synchronized level differs from the snapshot. On a read cycle it happens instead when the level changed in that same cycle.
- **CHG_PEND to CHG_IDLE** happens on a pin-register read in which the level did not change, or when the pin is disarmed.
- **Any other case** holds the current state.

A pin is armed when its change enable is set and its analog bit is clear. The port interrupt is high while any tracker is in CHG_PEND.

Top module: `gpio_port`

## Requirements
- R1: After reset all control registers are 0. Every pad output enable, drive value and pull-up is 0, every input buffer is enabled, and the interrupt is low.
- R2: Register 0 holds the direction bits, where 1 means output. An output pin with its alternate bit clear has its output enable set and drives the register 1 bit.
- R3: Register 2 holds the alternate-function bits. An output pin with its alternate bit set takes its drive value and output enable from the peripheral inputs for that pin.
- R4: On an input pin the pull-up enable equals the register 1 bit and the pad drive value is 0. An output pin never has its pull-up enabled.
- R5: Register 3 holds the analog bits. Setting a bit disables that pin's input buffer, makes that pin read as 0 in the pin register, and keeps its change tracker in CHG_IDLE.
- R6: A read of register 5 returns the pad levels in the same cycle, delayed by two clock edges through the synchronizer.
- R7: Register 4 holds the change-enable bits. An armed pin enters CHG_PEND one edge after its synchronized level differs from the snapshot. The interrupt output is the OR of all pending pins.
- R8: A read of register 5 latches the current synchronized levels as the new snapshot and returns trackers to CHG_IDLE.
- R9: An armed pin whose synchronized level changes in the same cycle as a register 5 read stays in, or enters, CHG_PEND.
- R10: Registers 0 to 4 read back the last value written. Writes to register 5 have no effect, and addresses 6 and 7 read as 0.
- R11: Clearing a pin's change-enable bit returns its tracker to CHG_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of register 5 takes the snapshot) |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational from the address |
| per_out | input | WIDTH | Peripheral drive value per pin |
| per_oe | input | WIDTH | Peripheral output enable per pin |
| pad_in | input | WIDTH | Asynchronous pad levels |
| pad_out | output | WIDTH | Pad drive value |
| pad_oe | output | WIDTH | Pad output enable |
| pad_pu | output | WIDTH | Pad pull-up enable |
| pad_ie | output | WIDTH | Pad input buffer enable |
| irq | output | 1 | Port change interrupt |

## Verification
A pin-register read and a new level change can happen in the same cycle. In that case the read must not lose the change. The bench changes a pad two cycles before a read, so that the synchronized edge arrives exactly on the read cycle. It then checks that the interrupt stays high after the read and clears only on a later read with no change. A behavioural model makes the same decision on every clock during a long stretch of random pad activity mixed with random reads, and the two are compared on every clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR = 3'd0,
        REG_DRV = 3'd1,
        REG_ALT = 3'd2,
        REG_ANA = 3'd3,
        REG_CHG = 3'd4,
        REG_PIN = 3'd5
    } reg_sel_e;

    typedef enum logic {
        CHG_IDLE = 1'b0,
        CHG_PEND = 1'b1
    } chg_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic [WIDTH-1:0]  pin_i,
    output logic [WIDTH-1:0]  rdata_o,
    output logic [WIDTH-1:0]  dir_o,
    output logic [WIDTH-1:0]  drv_o,
    output logic [WIDTH-1:0]  alt_o,
    output logic [WIDTH-1:0]  ana_o,
    output logic [WIDTH-1:0]  chg_o
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_o <= '0;
            drv_o <= '0;
            alt_o <= '0;
            ana_o <= '0;
            chg_o <= '0;
        end else if (wr_i) begin
            case (sel)
                REG_DIR: dir_o <= wdata_i;
                REG_DRV: drv_o <= wdata_i;
                REG_ALT: alt_o <= wdata_i;
                REG_ANA: ana_o <= wdata_i;
                REG_CHG: chg_o <= wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            REG_DIR: rdata_o = dir_o;
            REG_DRV: rdata_o = drv_o;
            REG_ALT: rdata_o = alt_o;
            REG_ANA: rdata_o = ana_o;
            REG_CHG: rdata_o = chg_o;
            REG_PIN: rdata_o = pin_i;
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dir_i,
    input  logic drv_i,
    input  logic alt_i,
    input  logic ana_i,
    input  logic chg_en_i,
    input  logic per_out_i,
    input  logic per_oe_i,
    input  logic sync_i,
    input  logic pin_rd_i,
    output logic pad_out_o,
    output logic pad_oe_o,
    output logic pad_pu_o,
    output logic pad_ie_o,
    output logic pin_val_o,
    output logic pend_o
);
    chg_state_e state_q, state_d;
    logic       snap_q;
    logic       prev_q;
    logic       armed;
    logic       edge_now;
    logic       mism;

    assign pin_val_o = sync_i & ~ana_i;
    assign armed     = chg_en_i & ~ana_i;
    assign edge_now  = pin_val_o != prev_q;
    assign mism      = pin_val_o != snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CHG_IDLE;
            snap_q  <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= pin_val_o;
            if (pin_rd_i) snap_q <= pin_val_o;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CHG_IDLE: begin
                if (armed && (pin_rd_i ? edge_now : mism)) state_d = CHG_PEND;
            end
            CHG_PEND: begin
                if (!armed)                     state_d = CHG_IDLE;
                else if (pin_rd_i && !edge_now) state_d = CHG_IDLE;
            end
        endcase
    end

    always_comb begin
        pad_ie_o  = ~ana_i;
        pad_pu_o  = ~dir_i & drv_i;
        pad_oe_o  = dir_i & (alt_i ? per_oe_i : 1'b1);
        pad_out_o = dir_i & (alt_i ? per_out_i : drv_i);
        pend_o    = (state_q == CHG_PEND);
    end

    // R11
    disarm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg_en_i || ana_i) |=> (state_q == CHG_IDLE));

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_rd_i && (pin_val_o == prev_q)) |=> (state_q == CHG_IDLE));

    // R9
    read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_rd_i && chg_en_i && !ana_i && (pin_val_o != prev_q)) |=> (state_q == CHG_PEND));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  per_out,
    input  logic [WIDTH-1:0]  per_oe,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu,
    output logic [WIDTH-1:0]  pad_ie,
    output logic              irq
);
    logic [WIDTH-1:0] dir_w, drv_w, alt_w, ana_w, chg_w;
    logic [WIDTH-1:0] sync_w, pin_w, pend_w;
    logic             pin_rd;

    assign pin_rd = bus_rd && (bus_addr == REG_PIN);

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(pad_in), .q_o(sync_w)
    );

    gpio_regs #(.WIDTH(WIDTH)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .pin_i(pin_w), .rdata_o(bus_rdata),
        .dir_o(dir_w), .drv_o(drv_w), .alt_o(alt_w), .ana_o(ana_w), .chg_o(chg_w)
    );

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        gpio_pin_slice slice_i (
            .clk(clk), .rst_n(rst_n),
            .dir_i(dir_w[p]), .drv_i(drv_w[p]), .alt_i(alt_w[p]),
            .ana_i(ana_w[p]), .chg_en_i(chg_w[p]),
            .per_out_i(per_out[p]), .per_oe_i(per_oe[p]),
            .sync_i(sync_w[p]), .pin_rd_i(pin_rd),
            .pad_out_o(pad_out[p]), .pad_oe_o(pad_oe[p]),
            .pad_pu_o(pad_pu[p]), .pad_ie_o(pad_ie[p]),
            .pin_val_o(pin_w[p]), .pend_o(pend_w[p])
        );
    end

    assign irq = |pend_w;

    // R5
    ana_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rd |-> ((bus_rdata & ana_w) == '0));

    // R4
    pu_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    // R7
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_w == '0) |=> !irq);
endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] per_out = '0, per_oe = '0, pad_in = '0;
    logic [7:0] pad_out, pad_oe, pad_pu, pad_ie;
    logic       irq;

    int n_chk = 0, n_bad = 0;

    logic [7:0] m_dir, m_drv, m_alt, m_ana, m_chg;
    logic [7:0] m_s1, m_s2, m_snap, m_prev, m_pend;

    always #5 clk = ~clk;

    gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .per_out(per_out), .per_oe(per_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pad_ie(pad_ie), .irq(irq)
    );

    task automatic model_reset();
        m_dir = '0; m_drv = '0; m_alt = '0; m_ana = '0; m_chg = '0;
        m_s1 = '0; m_s2 = '0; m_snap = '0; m_prev = '0; m_pend = '0;
    endtask

    task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%02h expected=%02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive, compare against model, advance model
    task automatic step(input string tag, input logic wr, input logic rd,
                        input logic [2:0] a, input logic [7:0] wd);
        logic [7:0] pv, exp_rd, nx_pend;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        #1;
        pv = m_s2 & ~m_ana;
        case (a)
            3'd0: exp_rd = m_dir;
            3'd1: exp_rd = m_drv;
            3'd2: exp_rd = m_alt;
            3'd3: exp_rd = m_ana;
            3'd4: exp_rd = m_chg;
            3'd5: exp_rd = pv;
            default: exp_rd = '0;
        endcase
        if (rd) cmp(tag, "rdata (R6/R10)", bus_rdata, exp_rd);
        cmp(tag, "pad_oe (R2/R3)", pad_oe, (m_dir & ~m_alt) | (m_dir & m_alt & per_oe));
        cmp(tag, "pad_out (R2/R3)", pad_out, m_dir & ((m_alt & per_out) | (~m_alt & m_drv)));
        cmp(tag, "pad_pu (R4)", pad_pu, ~m_dir & m_drv);
        cmp(tag, "pad_ie (R5)", pad_ie, ~m_ana);
        cmp(tag, "irq (R7)", {7'd0, irq}, {7'd0, |m_pend});
        @(posedge clk);
        for (int b = 0; b < 8; b++) begin
            logic armed;
            armed = m_chg[b] & ~m_ana[b];
            if (!armed) nx_pend[b] = 1'b0;
            else if (rd && a == 3'd5) nx_pend[b] = (pv[b] != m_prev[b]);
            else nx_pend[b] = m_pend[b] | (pv[b] != m_snap[b]);
        end
        m_pend = nx_pend;
        if (rd && a == 3'd5) m_snap = pv;
        m_prev = pv;
        m_s2 = m_s1;
        m_s1 = pad_in;
        if (wr) begin
            case (a)
                3'd0: m_dir = wd;
                3'd1: m_drv = wd;
                3'd2: m_alt = wd;
                3'd3: m_ana = wd;
                3'd4: m_chg = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 3'd0, 8'h00);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step("R1", 1'b0, 1'b1, 3'd0, 8'h00);
        cmp("R1", "irq after reset", {7'd0, irq}, 8'h00);

        // R2 R4 R10 direction and drive/pull-up
        step("R2", 1'b1, 1'b0, 3'd0, 8'hF0);
        step("R4", 1'b1, 1'b0, 3'd1, 8'hA5);
        step("R10", 1'b0, 1'b1, 3'd0, 8'h00);
        step("R10", 1'b0, 1'b1, 3'd1, 8'h00);

        // R3 alternate function
        per_out = 8'h5A; per_oe = 8'h9C;
        step("R3", 1'b1, 1'b0, 3'd2, 8'h30);
        step("R3", 1'b0, 1'b1, 3'd2, 8'h00);
        per_out = 8'hFF; per_oe = 8'h00;
        step("R3", 1'b0, 1'b0, 3'd0, 8'h00);

        // R10 write to pin register ignored, unused addresses read 0
        step("R10", 1'b1, 1'b0, 3'd5, 8'hFF);
        step("R10", 1'b0, 1'b1, 3'd0, 8'h00);
        step("R10", 1'b0, 1'b1, 3'd6, 8'h00);
        step("R10", 1'b0, 1'b1, 3'd7, 8'h00);

        // R5 R6 analog masking and synchronizer delay
        step("R5", 1'b1, 1'b0, 3'd3, 8'h01);
        pad_in = 8'hFF;
        step("R6", 1'b0, 1'b1, 3'd5, 8'h00);
        step("R6", 1'b0, 1'b1, 3'd5, 8'h00);
        step("R6", 1'b0, 1'b1, 3'd5, 8'h00);
        step("R5", 1'b0, 1'b1, 3'd5, 8'h00);

        // R7 R8 change interrupt and clear on read
        step("R7", 1'b1, 1'b0, 3'd4, 8'h0F);
        pad_in = 8'hFD;
        idle("R7", 4);
        step("R8", 1'b0, 1'b1, 3'd5, 8'h00);
        idle("R8", 2);

        // R9 change reaching synchronizer output on the read cycle
        pad_in = 8'hFF;
        idle("R9", 2);
        step("R9", 1'b0, 1'b1, 3'd5, 8'h00);
        cmp("R9", "irq held after coincident read", {7'd0, irq}, 8'h01);
        idle("R9", 2);
        step("R9", 1'b0, 1'b1, 3'd5, 8'h00);
        idle("R9", 1);

        // R5 analog pin never pends even when enabled
        step("R5", 1'b1, 1'b0, 3'd4, 8'h01);
        pad_in = 8'h00;
        idle("R5", 4);

        // R11 disabling drops pending
        step("R11", 1'b1, 1'b0, 3'd4, 8'h10);
        pad_in = 8'h10;
        idle("R11", 4);
        step("R11", 1'b1, 1'b0, 3'd4, 8'h00);
        idle("R11", 2);

        // random traffic against the model
        step("R7", 1'b1, 1'b0, 3'd3, 8'h80);
        step("R7", 1'b1, 1'b0, 3'd4, 8'h7F);
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) pad_in = lfsr[15:8];
            per_out = lfsr[7:0]; per_oe = lfsr[11:4];
            if (lfsr[5:3] < 3'd3) step("R9", 1'b0, 1'b1, 3'd5, 8'h00);
            else if (lfsr[5:3] == 3'd7) step("R2", 1'b1, 1'b0, {1'b0, lfsr[7:6]}, lfsr[15:8]);
            else step("R7", 1'b0, 1'b0, 3'd0, 8'h00);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule